// File: doc/BRIEF.md
# Cascaded 32-bit Free-Running Timer

Two 16-bit timers are chained so that together they form a 32-bit timebase. A free-running prescaler divides the core clock by four and gives a one-cycle tick. The low timer advances on each tick. The high timer can be set to step on the low timer's wrap pulse instead of the tick, so the pair counts as one wide counter. The high timer advances in the same cycle that the low timer returns to zero.

Each timer has three registers on a 16-bit register bus: a control word, a count and a max-compare value. A control write changes the enable and mode bits only if the write-enable bit is set in that same write. Software configures and zeroes the timers while they are stopped, then starts them with a second control write. To get a coherent 32-bit value, software reads the high count, then the low count, then the high count again, and repeats if the two high reads differ. Both counts are also available as outputs.

Top module: `casc_timer32`

## Requirements
- R1: After reset both counts are 0, both control words read 0x0000, and the prescaler phase is 0.
- R2: An enabled timer stepping on the prescaler tick advances exactly once every 2^PSC_W clock cycles (every 4 cycles at the default). The first tick falls on the 4th rising edge after reset is released.
- R3: With max-compare 0 and continuous mode on, the count runs through its full range and wraps from all ones to 0.
- R4: With max-compare N > 0, the count wraps to 0 on the step after it reaches N. A count above N also wraps to 0 on its next step.
- R5: With control bit 3 (cascade) set, the high timer advances once per low-timer wrap, in the same cycle the low count becomes 0. With bit 3 clear, it steps on the prescaler tick. The low timer has no cascade bit, so bit 3 reads back 0 for it.
- R6: A control write takes effect only if bit 14 (write-enable) is set. Otherwise bits 15 (enable), 5 (continuous) and 3 (cascade) stay unchanged. Bit 14 always reads back 0.
- R7: A count write loads the value on the next rising edge and takes priority over a step in the same cycle. A write that replaces a wrapping step also suppresses that cycle's wrap pulse, so the cascaded high timer does not advance.
- R8: With continuous mode off, the timer wraps to 0 once, clears its enable bit and then holds.
- R9: Register addresses are: 0 low control, 1 low count, 2 low max, 3 high control, 4 high count, 5 high max. Addresses 6 and 7 read 0 and ignore writes. Reads are combinational, and a count read equals the matching count output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| lo_cnt_o | output | CNT_W | Low timer count |
| hi_cnt_o | output | CNT_W | High timer count |

## Verification
The bench builds the block with CNT_W = 4 and PSC_W = 2. This keeps the tick spacing the same as the default, and the combined count of two 4-bit timers wraps after only 256 ticks. With this setting the bench can sweep every combined value through a complete cascade wrap, checking tick spacing at each step. It also runs every low max-compare value from 1 to 6, the uncascaded mode, a count write placed exactly on a wrapping tick, and a one-shot stop. All expected values are computed from the tick index.

// File: rtl/casc_timer_pkg.sv
package casc_timer_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_LO_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_LO_CNT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LO_MAX  = 3'd2;
  localparam logic [ADDR_W-1:0] A_HI_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] A_HI_CNT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_HI_MAX  = 3'd5;

  localparam int B_EN   = 15;
  localparam int B_WEN  = 14;
  localparam int B_CONT = 5;
  localparam int B_CASC = 3;

  typedef struct packed {
    logic en;
    logic cont;
    logic casc;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_word(ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[B_EN]   = c.en;
    w[B_CONT] = c.cont;
    w[B_CASC] = c.casc;
    return w;
  endfunction
endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
  parameter int PSC_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic [PSC_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= q + 1'b1;
  end

  assign tick_o = &q;
endmodule

// File: rtl/ct_timer.sv
module ct_timer
  import casc_timer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter bit HAS_CASC = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             casc_step_i,
  input  logic             cnt_wr_i,
  input  logic             max_wr_i,
  input  logic             ctrl_wr_i,
  input  logic [CNT_W-1:0] wval_i,
  input  ctrl_t            wctrl_i,
  input  logic             wen_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] max_o,
  output ctrl_t            ctrl_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, max_q, term;
  ctrl_t ctrl_q;
  logic  step, adv, wrap;

  generate
    if (HAS_CASC) begin : g_casc
      assign step = ctrl_q.casc ? casc_step_i : tick_i;
    end else begin : g_tick
      assign step = tick_i;
    end
  endgenerate

  assign term = (max_q == '0) ? '1 : max_q;
  assign adv  = ctrl_q.en && step;
  // a count write replaces the step and its wrap
  assign wrap = adv && (cnt_q >= term) && !cnt_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_wr_i) begin
      cnt_q <= wval_i;
    end else if (wrap) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       max_q <= '0;
    else if (max_wr_i) max_q <= wval_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_wr_i && wen_i) begin
      ctrl_q.en   <= wctrl_i.en;
      ctrl_q.cont <= wctrl_i.cont;
      ctrl_q.casc <= HAS_CASC ? wctrl_i.casc : 1'b0;
    end else if (wrap && !ctrl_q.cont) begin
      ctrl_q.en <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign max_o  = max_q;
  assign ctrl_o = ctrl_q;
  assign wrap_o = wrap;
endmodule

// File: rtl/casc_timer32.sv
module casc_timer32
  import casc_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  lo_cnt_o,
  output logic [CNT_W-1:0]  hi_cnt_o
);
  logic tick, lo_wrap, hi_wrap;
  logic [CNT_W-1:0] lo_cnt, hi_cnt, lo_max, hi_max;
  ctrl_t lo_ctrl, hi_ctrl, wctrl;

  assign wctrl.en   = wdata_i[B_EN];
  assign wctrl.cont = wdata_i[B_CONT];
  assign wctrl.casc = wdata_i[B_CASC];

  ct_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  ct_timer #(.CNT_W(CNT_W), .HAS_CASC(1'b0)) u_lo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .casc_step_i(1'b0),
    .cnt_wr_i   (wr_i && addr_i == A_LO_CNT),
    .max_wr_i   (wr_i && addr_i == A_LO_MAX),
    .ctrl_wr_i  (wr_i && addr_i == A_LO_CTRL),
    .wval_i     (wdata_i[CNT_W-1:0]),
    .wctrl_i    (wctrl),
    .wen_i      (wdata_i[B_WEN]),
    .cnt_o      (lo_cnt),
    .max_o      (lo_max),
    .ctrl_o     (lo_ctrl),
    .wrap_o     (lo_wrap)
  );

  ct_timer #(.CNT_W(CNT_W), .HAS_CASC(1'b1)) u_hi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .casc_step_i(lo_wrap),
    .cnt_wr_i   (wr_i && addr_i == A_HI_CNT),
    .max_wr_i   (wr_i && addr_i == A_HI_MAX),
    .ctrl_wr_i  (wr_i && addr_i == A_HI_CTRL),
    .wval_i     (wdata_i[CNT_W-1:0]),
    .wctrl_i    (wctrl),
    .wen_i      (wdata_i[B_WEN]),
    .cnt_o      (hi_cnt),
    .max_o      (hi_max),
    .ctrl_o     (hi_ctrl),
    .wrap_o     (hi_wrap)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_LO_CTRL: rdata_o = ctrl_word(lo_ctrl);
      A_LO_CNT:  rdata_o[CNT_W-1:0] = lo_cnt;
      A_LO_MAX:  rdata_o[CNT_W-1:0] = lo_max;
      A_HI_CTRL: rdata_o = ctrl_word(hi_ctrl);
      A_HI_CNT:  rdata_o[CNT_W-1:0] = hi_cnt;
      A_HI_MAX:  rdata_o[CNT_W-1:0] = hi_max;
      default:   rdata_o = '0;
    endcase
  end

  assign lo_cnt_o = lo_cnt;
  assign hi_cnt_o = hi_cnt;
endmodule

// File: rtl/casc_timer32_chk.sv
module casc_timer32_chk
  import casc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              tick_i,
  input logic [CNT_W-1:0]  lo_cnt_i,
  input logic [CNT_W-1:0]  hi_cnt_i,
  input logic [CNT_W-1:0]  lo_max_i,
  input logic              lo_wrap_i,
  input ctrl_t             lo_ctrl_i,
  input ctrl_t             hi_ctrl_i
);
  logic lo_cw, hi_cw, lo_mw, lo_ctw, hi_ctw;
  assign lo_cw  = wr_i && addr_i == A_LO_CNT;
  assign hi_cw  = wr_i && addr_i == A_HI_CNT;
  assign lo_mw  = wr_i && addr_i == A_LO_MAX;
  assign lo_ctw = wr_i && addr_i == A_LO_CTRL;
  assign hi_ctw = wr_i && addr_i == A_HI_CTRL;

  p_step_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lo_cw && lo_ctrl_i.en && !tick_i) |=> $stable(lo_cnt_i));

  p_full_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_ctrl_i.en && tick_i && lo_max_i == '0 && (&lo_cnt_i) && !lo_cw)
    |=> lo_cnt_i == '0);

  p_max_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_max_i != '0 && lo_cnt_i <= lo_max_i && !lo_cw && !lo_mw)
    |=> lo_cnt_i <= lo_max_i);

  p_cascade_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_ctrl_i.en && hi_ctrl_i.casc && lo_wrap_i && !hi_cw && !hi_ctw)
    |=> (hi_cnt_i == CNT_W'($past(hi_cnt_i) + 1'b1) && lo_cnt_i == '0));

  p_ctrl_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_ctw && !wdata_i[B_WEN]) |=> ($stable(lo_ctrl_i.cont) && $stable(lo_ctrl_i.casc)));

  p_cnt_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_cw |=> lo_cnt_i == $past(wdata_i[CNT_W-1:0]));

  p_oneshot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_wrap_i && !lo_ctrl_i.cont && !lo_ctw) |=> !lo_ctrl_i.en);
endmodule

bind casc_timer32 casc_timer32_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .tick_i   (tick),
  .lo_cnt_i (lo_cnt),
  .hi_cnt_i (hi_cnt),
  .lo_max_i (lo_max),
  .lo_wrap_i(lo_wrap),
  .lo_ctrl_i(lo_ctrl),
  .hi_ctrl_i(hi_ctrl)
);

// File: tb/casc_timer32_tb_top.sv
module casc_timer32_tb_top;
  localparam int CW = 4;
  localparam int M  = 1 << CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [CW-1:0] lo, hi;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  casc_timer32 #(.CNT_W(CW), .PSC_W(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .lo_cnt_o(lo), .hi_cnt_o(hi)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  // follow ticks from zeroed counts; every step checked against the tick index
  task automatic observe(int ticks, int plo, bit casc, string req);
    logic [CW-1:0] prev;
    int gap, t, elo, ehi;
    t = 0;
    for (int k = 0; k < ticks; k++) begin
      prev = lo; gap = 0;
      do begin @(negedge clk); gap++; end while (lo == prev && gap < 40);
      t++;
      elo = t % plo;
      ehi = casc ? (t / plo) % M : t % M;
      chk(lo == CW'(elo), {req, " lo"}, lo, elo);
      chk(hi == CW'(ehi), casc ? "R5 hi cascade" : "R5 hi on tick", hi, ehi);
      if (k > 0) chk(gap == 4, "R2 tick spacing", gap, 4);
    end
  endtask

  task automatic stop_zero(logic [15:0] lmax);
    bus_wr(3'd0, 16'h4020);
    bus_wr(3'd3, 16'h4028);
    bus_wr(3'd2, lmax);
    bus_wr(3'd5, 16'h0000);
    bus_wr(3'd1, 16'h0000);
    bus_wr(3'd4, 16'h0000);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] d, h1, l1, h2;
    logic [CW-1:0] hsave;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(lo == 0, "R1 lo reset", lo, 0);
    chk(hi == 0, "R1 hi reset", hi, 0);
    bus_rd(3'd0, d); chk(d == 16'h0, "R1 lo ctrl reset", d, 0);
    bus_rd(3'd3, d); chk(d == 16'h0, "R1 hi ctrl reset", d, 0);
    rst_n = 1'b1;

    // R6 gated write: no write-enable bit
    bus_wr(3'd0, 16'h8028);
    bus_rd(3'd0, d); chk(d == 16'h0, "R6 ungated ctrl write ignored", d, 0);
    repeat (12) @(negedge clk);
    chk(lo == 0, "R6 timer not started", lo, 0);
    bus_wr(3'd0, 16'h4028);
    bus_rd(3'd0, d); chk(d == 16'h0020, "R6 cont loaded, R5 lo has no casc", d, 16'h0020);
    // R9 unmapped addresses
    bus_wr(3'd6, 16'hFFFF);
    bus_rd(3'd6, d); chk(d == 0, "R9 addr 6 reads 0", d, 0);
    bus_rd(3'd7, d); chk(d == 0, "R9 addr 7 reads 0", d, 0);

    // R3/R5 full cascaded sweep, high started first
    bus_wr(3'd3, 16'hC028);
    bus_wr(3'd0, 16'hC020);
    observe(M * M + 8, M, 1'b1, "R3 full range");
    // R6 ungated write while running keeps it running
    bus_wr(3'd0, 16'h0000);
    bus_rd(3'd0, d); chk(d == 16'h8020, "R6 running ctrl unchanged", d, 16'h8020);
    // R9 hi-lo-hi coherent read
    bus_rd(3'd4, h1); bus_rd(3'd1, l1); bus_rd(3'd4, h2);
    chk(l1[CW-1:0] == lo, "R9 lo read matches port", l1, lo);
    chk(h2[CW-1:0] == hi, "R9 hi read matches port", h2, hi);
    chk(h1 == h2 || h2 == h1 + 1 || (h1 == M - 1 && h2 == 0), "R9 hi samples", h2, h1);

    // R4 max-compare sweep
    for (int n = 1; n <= 6; n++) begin
      stop_zero(16'(n));
      bus_wr(3'd3, 16'hC028);
      bus_wr(3'd0, 16'hC020);
      observe(3 * (n + 1) + 2, n + 1, 1'b1, "R4 max compare");
    end

    // R5 uncascaded high counts ticks
    stop_zero(16'h0000);
    bus_wr(3'd3, 16'hC020);
    bus_wr(3'd0, 16'hC020);
    @(negedge clk);
    bus_wr(3'd4, 16'(lo));
    begin
      logic [CW-1:0] p; int g;
      for (int k = 0; k < 20; k++) begin
        p = lo; g = 0;
        do begin @(negedge clk); g++; end while (lo == p && g < 40);
        chk(hi == lo, "R5 uncascaded hi tracks tick", hi, lo);
      end
    end

    // R7 count write placed on a wrapping tick suppresses the cascade
    stop_zero(16'h0000);
    bus_wr(3'd3, 16'hC028);
    bus_wr(3'd0, 16'hC020);
    bus_wr(3'd1, 16'(M - 2));
    begin
      logic [CW-1:0] p; int g;
      p = lo; g = 0;
      do begin @(negedge clk); g++; end while (lo == p && g < 40);
      chk(lo == CW'(M - 1), "R7 loaded value counted", lo, M - 1);
      hsave = hi;
      repeat (3) @(negedge clk);
      wr = 1'b1; addr = 3'd1; wdata = 16'd5;
      @(negedge clk);
      wr = 1'b0;
      chk(lo == 5, "R7 write beats step", lo, 5);
      chk(hi == hsave, "R7 wrap suppressed", hi, hsave);
    end

    // R8 one-shot
    stop_zero(16'h0003);
    bus_wr(3'd3, 16'hC028);
    bus_wr(3'd0, 16'h4000);
    bus_wr(3'd0, 16'hC000);
    repeat (40) @(negedge clk);
    chk(lo == 0, "R8 one-shot holds 0", lo, 0);
    chk(hi == 1, "R8 one wrap seen by high", hi, 1);
    bus_rd(3'd0, d); chk(d == 16'h0, "R8 enable cleared", d, 0);
    bus_rd(3'd2, d); chk(d == 16'h3, "R9 lo max readback", d, 3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule